// File: doc/BRIEF.md
# Serial EEPROM Configuration Loader

After the active-low reset is released, this block acts on its own as a two-wire (I2C) master. It fetches a fixed run of configuration bytes from an external serial EEPROM and hands each byte to the chip's register file through a simple write port. Byte k goes to register k, and the bytes arrive in rising address order. Register addresses flagged as read-only in a parameter mask are read from the EEPROM but never written. When the load ends, `done` goes high and stays high until the next reset.

The bus transfer has a fixed shape. First comes a dummy write that sets the EEPROM word pointer to zero. A repeated START follows, then one sequential read covering every byte. The master acknowledges each byte except the final one, then sends a STOP. If no device acknowledges its address, the block writes nothing and raises `absent` together with `done`, so the registers keep their default and strap values.

Both bus lines are open-drain. Each is modelled as a pull-low enable plus a sensed input. The SCL period is four divider steps of `DIV` clocks each, and a slave that holds SCL low stretches the high phase.

Top module: `cfg_eeprom_loader`

## Requirements
- R1: While reset is asserted, both pull-low enables and `reg_we` are 0 and `done` is 0. After reset is released, the load starts without any further input.
- R2: Each load places on the bus, in this order: START, device address `DEV_ADDR` with R/W bit 0, word address 0x00, repeated START, `DEV_ADDR` with R/W bit 1, `NUM_REGS` read bytes, STOP. This gives exactly two START conditions and one STOP. SDA changes while SCL is high only for these conditions.
- R3: The master drives ACK (SDA low) after each of the first `NUM_REGS-1` bytes it reads and NACK (SDA released) after the last.
- R4: The byte read in position k is written with a one-cycle `reg_we` pulse, `reg_addr` = k and `reg_data` = the EEPROM byte at address k. Addresses strictly increase within a load.
- R5: No write is issued for an address k with `RO_MASK[k]` = 1, including the final address.
- R6: If the device address is not acknowledged, the block issues a STOP and performs no register write, and ends with `absent` = 1 and `done` = 1. After a successful load `absent` = 0.
- R7: Once `done` is 1, it stays 1 until reset, and both pull-low enables stay 0.
- R8: With no stretching, consecutive SCL rising edges are 4·`DIV` clocks apart. While the slave holds SCL low, the master does not advance, so a stretched load takes longer and still delivers the same data.
- R9: Without stretching, `done` rises at most `DIV`·(36·(`NUM_REGS`+3)+16) clocks after reset release. With the defaults (`DIV`=312 at 125 MHz, 100 kHz SCL) this is about 10.2 ms, inside 15 ms. With no device present it rises within `DIV`·48 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Sensed level of the SCL line |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_i | input | 1 | Sensed level of the SDA line |
| sda_oe | output | 1 | Pull SDA low when 1 |
| reg_addr | output | $clog2(NUM_REGS+1) | Register file write address |
| reg_data | output | 8 | Register file write data |
| reg_we | output | 1 | One-cycle register write strobe |
| done | output | 1 | Load finished (sticky until reset) |
| absent | output | 1 | No EEPROM acknowledged its address |

## Verification
The bench keeps the full 110-register block and the real device address, so the complete sequential read and its final NACK are covered. It lowers `DIV` to 4, which makes a full load take about sixteen thousand clocks. A load with clock stretching and a run with no EEPROM can then share one run with the plain load. The read-only mask marks registers 0, 1, 7, 50 and 109. This covers skipped addresses at the start, in the middle, and on the NACKed final byte.

// File: rtl/cfg_eeprom_loader.sv
module cfg_eeprom_loader #(
  parameter int NUM_REGS = 110,
  parameter int DIV = 312,
  parameter logic [6:0] DEV_ADDR = 7'h50,
  parameter logic [NUM_REGS-1:0] RO_MASK = {{(NUM_REGS-2){1'b0}}, 2'b11},
  localparam int AW = $clog2(NUM_REGS+1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_i,
  output logic          scl_oe,
  input  logic          sda_i,
  output logic          sda_oe,
  output logic [AW-1:0] reg_addr,
  output logic [7:0]    reg_data,
  output logic          reg_we,
  output logic          done,
  output logic          absent
);
  localparam int DW = $clog2(DIV);

  typedef enum logic [2:0] {IDLE, START, TX, RX, STOP, FIN} st_t;

  st_t           st;
  logic [DW-1:0] dcnt;
  logic [1:0]    ph;
  logic [3:0]    bitn;
  logic [1:0]    txsel;
  logic [AW-1:0] idx;
  logic [6:0]    rxsh;
  logic [7:0]    txbyte;
  logic          tick, adv, last, scl_low;

  assign tick    = (dcnt == DW'(DIV-1));
  assign adv     = tick && !(ph == 2'd1 && !scl_i);
  assign last    = (idx == AW'(NUM_REGS));
  assign done    = (st == FIN);
  assign scl_low = (ph == 2'd0) || (ph == 2'd3);
  assign txbyte  = (txsel == 2'd0) ? {DEV_ADDR, 1'b0} :
                   (txsel == 2'd1) ? 8'h00 : {DEV_ADDR, 1'b1};

  always_comb begin
    scl_oe = 1'b0;
    sda_oe = 1'b0;
    case (st)
      START: begin scl_oe = scl_low; sda_oe = ph[1]; end
      TX:    begin scl_oe = scl_low; sda_oe = (bitn < 4'd8) && !txbyte[3'd7 - bitn[2:0]]; end
      RX:    begin scl_oe = scl_low; sda_oe = (bitn == 4'd8) && !last; end
      STOP:  begin scl_oe = (ph == 2'd0); sda_oe = !ph[1]; end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= IDLE;
      dcnt     <= '0;
      ph       <= '0;
      bitn     <= '0;
      txsel    <= '0;
      idx      <= '0;
      rxsh     <= '0;
      reg_we   <= 1'b0;
      reg_addr <= '0;
      reg_data <= '0;
      absent   <= 1'b0;
    end else begin
      reg_we <= 1'b0;
      dcnt   <= tick ? '0 : dcnt + 1'b1;
      if (adv) begin
        case (st)
          IDLE: st <= START;
          START: begin
            ph <= ph + 1'b1;
            if (ph == 2'd3) begin st <= TX; bitn <= '0; end
          end
          TX: begin
            ph <= ph + 1'b1;
            if (ph == 2'd2 && bitn == 4'd8 && sda_i) absent <= 1'b1;
            if (ph == 2'd3) begin
              bitn <= bitn + 4'd1;
              if (bitn == 4'd8) begin
                bitn <= '0;
                if (absent)               st <= STOP;
                else if (txsel == 2'd1) begin txsel <= 2'd2; st <= START; end
                else if (txsel == 2'd2)   st <= RX;
                else                      txsel <= 2'd1;
              end
            end
          end
          RX: begin
            ph <= ph + 1'b1;
            if (ph == 2'd2 && bitn < 4'd8) begin
              rxsh <= {rxsh[5:0], sda_i};
              if (bitn == 4'd7) begin
                reg_we   <= !RO_MASK[idx];
                reg_addr <= idx;
                reg_data <= {rxsh, sda_i};
                idx      <= idx + 1'b1;
              end
            end
            if (ph == 2'd3) begin
              bitn <= bitn + 4'd1;
              if (bitn == 4'd8) begin
                bitn <= '0;
                if (last) st <= STOP;
              end
            end
          end
          STOP: begin
            ph <= ph + 1'b1;
            if (ph == 2'd3) st <= FIN;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/cfg_eeprom_loader_chk.sv
module cfg_eeprom_loader_chk #(
  parameter int NUM_REGS = 110,
  parameter int AW = 7,
  parameter logic [NUM_REGS-1:0] RO_MASK = '0
) (
  input logic          clk,
  input logic          rst_n,
  input logic          scl_oe,
  input logic          sda_oe,
  input logic          reg_we,
  input logic          done,
  input logic          absent,
  input logic [AW-1:0] reg_addr
);
  logic          wrote;
  logic [AW-1:0] prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wrote <= 1'b0;
      prev  <= '0;
    end else if (reg_we) begin
      wrote <= 1'b1;
      prev  <= reg_addr;
    end
  end

  // R4
  ascending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && wrote) |-> (reg_addr > prev));

  // R4
  strobe_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> !reg_we);

  // R5
  ro_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> !RO_MASK[reg_addr]);

  // R6
  absent_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    absent |-> (!reg_we && !wrote));

  // R7
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done);

  // R7
  done_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!scl_oe && !sda_oe));
endmodule

bind cfg_eeprom_loader cfg_eeprom_loader_chk #(
  .NUM_REGS(NUM_REGS), .AW(AW), .RO_MASK(RO_MASK)
) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_oe(scl_oe), .sda_oe(sda_oe),
  .reg_we(reg_we), .done(done), .absent(absent), .reg_addr(reg_addr)
);

// File: tb/cfg_eeprom_loader_tb.sv
module cfg_eeprom_loader_tb;
  localparam int N = 110;
  localparam int DIV = 4;
  localparam logic [6:0] DEV = 7'h50;
  localparam logic [N-1:0] MASK = (N'(1) << 0) | (N'(1) << 1) | (N'(1) << 7) |
                                  (N'(1) << 50) | (N'(1) << 109);
  localparam int AW = $clog2(N+1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic scl_oe, sda_oe, reg_we, done, absent;
  logic [AW-1:0] reg_addr;
  logic [7:0] reg_data;
  logic stretch = 1'b0;
  logic slv_oe = 1'b0;
  wire scl_line = ~(scl_oe | stretch);
  wire sda_line = ~(sda_oe | slv_oe);

  cfg_eeprom_loader #(.NUM_REGS(N), .DIV(DIV), .DEV_ADDR(DEV), .RO_MASK(MASK)) u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .scl_oe(scl_oe),
    .sda_i(sda_line), .sda_oe(sda_oe), .reg_addr(reg_addr), .reg_data(reg_data),
    .reg_we(reg_we), .done(done), .absent(absent));

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  // EEPROM slave model
  logic [7:0] mem [N];
  bit present = 1;
  bit stretch_en = 0;
  int mode = 0, bitc = 0, ptr = 0;
  logic [7:0] sh = '0;
  bit rd = 0, mnack = 0;
  logic ps = 1'b1, pd = 1'b1;
  int starts = 0, stops = 0, macks = 0, mnacks = 0, waddr = -1;
  time p1 = 0, p2 = 0;

  always @(scl_line, sda_line, negedge rst_n) begin
    if (!rst_n) begin
      starts = 0; stops = 0; macks = 0; mnacks = 0; waddr = -1;
      p1 = 0; p2 = 0; mode = 0; slv_oe = 1'b0;
    end else if (ps === 1'b1 && scl_line === 1'b1 && pd === 1'b1 && sda_line === 1'b0) begin
      starts++; mode = 1; bitc = -1; slv_oe = 1'b0;
    end else if (ps === 1'b1 && scl_line === 1'b1 && pd === 1'b0 && sda_line === 1'b1) begin
      stops++; mode = 0; slv_oe = 1'b0;
    end else if (ps !== 1'b1 && scl_line === 1'b1) begin
      if (p1 == 0) p1 = $time; else if (p2 == 0) p2 = $time;
      if ((mode == 1 || mode == 2) && bitc >= 0 && bitc < 8) sh = {sh[6:0], sda_line};
      if (mode == 3 && bitc == 8) begin
        mnack = sda_line;
        if (sda_line) mnacks++; else macks++;
      end
    end else if (ps === 1'b1 && scl_line === 1'b0 && mode != 0) begin
      bitc++;
      if (mode == 1 || mode == 2) begin
        if (bitc == 8) begin
          if (mode == 1) begin
            if (present && sh[7:1] == DEV) begin slv_oe = 1'b1; rd = sh[0]; end
            else begin mode = 0; slv_oe = 1'b0; end
          end else begin
            ptr = int'(sh); waddr = ptr; slv_oe = 1'b1;
          end
        end else if (bitc == 9) begin
          slv_oe = 1'b0; bitc = 0;
          if (mode == 1) begin
            if (rd) begin mode = 3; slv_oe = ~mem[ptr % N][7]; end
            else mode = 2;
          end else mode = 4;
        end
      end else if (mode == 3) begin
        if (bitc < 8) slv_oe = ~mem[ptr % N][7 - bitc];
        else if (bitc == 8) slv_oe = 1'b0;
        else begin
          ptr++; bitc = 0;
          if (mnack) begin mode = 0; slv_oe = 1'b0; end
          else slv_oe = ~mem[ptr % N][7];
        end
      end
    end
    ps = scl_line;
    pd = sda_line;
  end

  always @(negedge scl_line) begin
    if (stretch_en && rst_n) begin
      stretch = 1'b1;
      repeat (3*DIV) @(posedge clk);
      stretch = 1'b0;
    end
  end

  // scoreboard
  typedef struct { int a; int d; } item_t;
  item_t q[$];
  int writes = 0;

  task automatic push_expected();
    for (int i = 0; i < N; i++)
      if (!MASK[i]) q.push_back('{i, int'(mem[i])});
  endtask

  always @(negedge clk) begin
    if (!rst_n) writes = 0;
    else if (reg_we === 1'b1) begin
      writes++;
      if (q.size() == 0) chk(0, "R5/R6 unexpected write addr", int'(reg_addr), -1);
      else begin
        item_t e;
        e = q.pop_front();
        chk(int'(reg_addr) == e.a, "R4 write address", int'(reg_addr), e.a);
        chk(int'(reg_data) == e.d, "R4 write data", int'(reg_data), e.d);
      end
    end
  end

  task automatic run(input bit pres, input bit strch, input int seed, output int cyc);
    for (int i = 0; i < N; i++) mem[i] = 8'((i * 37 + seed * 91 + 5) ^ (i >> 2));
    present = pres;
    stretch_en = strch;
    q.delete();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(done == 1'b0, "R1 done low in reset", int'(done), 0);
    chk(!scl_oe && !sda_oe, "R1 lines released in reset", int'({scl_oe, sda_oe}), 0);
    chk(reg_we == 1'b0, "R1 no strobe in reset", int'(reg_we), 0);
    if (pres) push_expected();
    rst_n = 1'b1;
    cyc = 0;
    while (!done && cyc < 60000) begin @(negedge clk); cyc++; end
    chk(done == 1'b1, "R1 load completes after reset release", int'(done), 1);
    repeat (20) @(negedge clk);
    chk(done == 1'b1, "R7 done stays high", int'(done), 1);
    chk(!scl_oe && !sda_oe, "R7 lines released when done", int'({scl_oe, sda_oe}), 0);
  endtask

  initial begin
    int c1, c2, c3;
    // plain load
    run(1, 0, 1, c1);
    chk(q.size() == 0, "R4 all expected writes seen", q.size(), 0);
    chk(writes == N - $countones(MASK), "R5 write count skips read-only", writes, N - $countones(MASK));
    chk(starts == 2, "R2 START count", starts, 2);
    chk(stops == 1, "R2 STOP count", stops, 1);
    chk(waddr == 0, "R2 word address zero", waddr, 0);
    chk(macks == N - 1, "R3 master ACK count", macks, N - 1);
    chk(mnacks == 1, "R3 final NACK", mnacks, 1);
    chk(absent == 1'b0, "R6 absent low when present", int'(absent), 0);
    chk(int'(p2 - p1) == 4 * DIV * 8, "R8 SCL period", int'(p2 - p1), 4 * DIV * 8);
    chk(c1 <= DIV * (36 * (N + 3) + 16), "R9 load time bound", c1, DIV * (36 * (N + 3) + 16));
    // no EEPROM
    run(0, 0, 2, c2);
    chk(absent == 1'b1, "R6 absent flagged", int'(absent), 1);
    chk(writes == 0, "R6 no register writes", writes, 0);
    chk(starts == 1 && stops == 1, "R6 STOP after address NACK", starts * 10 + stops, 11);
    chk(c2 <= DIV * 48, "R9 absent time bound", c2, DIV * 48);
    // stretched load
    run(1, 1, 3, c3);
    chk(q.size() == 0, "R8 stretched load delivers all bytes", q.size(), 0);
    chk(c3 > c1, "R8 stretching slows the load", c3, c1 + 1);
    chk(absent == 1'b0, "R6 absent cleared by reset", int'(absent), 0);
    finish_up();
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired (R1) actual=0 expected=1");
    finish_up();
  end
endmodule